// File: doc/BRIEF.md
# Serial Memory Slave Front-End with Hold and Deferred Write Commit

This block is the serial slave side of a small byte-addressed memory. A host talks to it over a four-wire serial bus: a chip select (active low), a serial clock, a data input and a data output, plus an active-low pause input. All bus pins are oversampled by the system clock through a synchronizer, so the serial clock must run several times slower than `clk`. Bits on the data input are taken on rising serial-clock edges. The data output changes on falling edges, which makes clock-idle-low (mode 0) and clock-idle-high (mode 3) hosts both work. The data output comes as a value and a drive enable for the pad.

Commands are one opcode byte, followed by an address byte and a data byte where the command needs them. Write-type commands do nothing while chip select is low. When chip select rises after a complete frame that is allowed, the block offers the captured write on a valid/ready commit port to the protection logic. The array or the protection bits change only at the handshake. The handshake starts a self-timed busy period of fixed length. Reads stream bytes out and move through the array in a loop, wrapping at the top. A pause input freezes a transfer at its current bit and lets it carry on later.

Top module: `spimem_slave`

## Requirements
- R1: SI is sampled on rising SCK edges and SO changes on falling SCK edges. A host using mode 0 or mode 3 gets the same read data, MSB first.
- R2: While cs_n is high, so_oe is 0. SCK and SI activity while cs_n is high changes no state.
- R3: The status byte returned by opcode 0x05 is {protect_en, 1, 1, 1, bp[1:0], wel, busy}. Bit 0 is busy and bit 1 is the write-enable latch. After reset it reads 0x70.
- R4: Opcode 0x06 sets wel and opcode 0x04 clears it. Each takes effect on the rising edge of cs_n, and only when exactly 8 bits were clocked in the frame.
- R5: Opcode 0x02 (address, data) raises commit_valid only when cs_n rises after exactly 24 bits, with wel set and the block not busy. Any other bit count, or wel clear, is discarded with no commit.
- R6: Opcode 0x01 followed by one byte d, when cs_n rises after exactly 16 bits with wel set and the block not busy, commits with commit_is_status=1. At the handshake, protect_en takes d[7] and bp takes d[3:2].
- R7: commit_valid stays high with commit_addr and commit_data stable until commit_ready. The update, the clearing of wel and the start of busy happen in the handshake cycle. The busy bit reads 1 while a commit is pending.
- R8: After each handshake, busy stays set for WRITE_CYCLES clocks. A write or status-write frame that ends while busy is dropped, and wel keeps its value.
- R9: Opcode 0x03 followed by an address streams bytes from that address upward, wrapping from the top address to 0, for as long as cs_n stays low.
- R10: When hold_n falls while SCK is low, the transfer pauses. so_oe is 0 and SCK/SI edges are ignored. When hold_n rises while SCK is low, the transfer resumes at the same bit.
- R11: After reset, so_oe and commit_valid are 0 and the array reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause request, active low |
| so_d | output | 1 | Serial data value toward host |
| so_oe | output | 1 | Drive enable for the SO pad |
| commit_valid | output | 1 | A captured write awaits acceptance |
| commit_ready | input | 1 | Protection logic accepts the write |
| commit_is_status | output | 1 | 1 = status write, 0 = array write |
| commit_addr | output | 8 | Array address of the write |
| commit_data | output | 8 | Byte to be written |

## Verification
The hardest case to reach is a pause that lands inside the data phase of a read. The output bit for the current position has already been shifted, and the pause then sees a full extra SCK pulse together with SI toggling before it is released. The bench's transfer task takes a bit index at which to stop. At that bit it holds SCK low, drops hold_n, checks that the pad is released, sends a dummy clock pulse with flipped SI, and releases hold_n with SCK low. The byte read back must still be exact. A second hard case is a write frame that ends during a busy period. The bench issues it right after an accepted write, so that it falls inside the WRITE_CYCLES window, and counts handshakes to show that nothing further was offered.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  // status byte layout: {protect_en, 3'b111, bp[1:0], wel, busy}
  function automatic logic [7:0] pack_status(input logic pen, input logic [1:0] bp,
                                             input logic wel, input logic busy);
    return {pen, 3'b111, bp, wel, busy};
  endfunction
endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_VAL;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spimem_array.sv
module spimem_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spimem_slave.sv
module spimem_slave #(
  parameter int AW = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  input  logic       hold_n,
  output logic       so_d,
  output logic       so_oe,
  output logic       commit_valid,
  input  logic       commit_ready,
  output logic       commit_is_status,
  output logic [7:0] commit_addr,
  output logic [7:0] commit_data
);
  import spimem_pkg::*;
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  // synchronized bus pins
  logic [3:0] pins_s;
  logic sck_s, cs_s, hold_s, si_s;
  spimem_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, cs_n, hold_n, si}), .q(pins_s));
  assign {sck_s, cs_s, hold_s, si_s} = pins_s;

  logic sck_q, cs_q, held;
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = sck_s & ~sck_q & ~cs_s & ~held;
  assign sck_fall = ~sck_s & sck_q & ~cs_s & ~held;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      held  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      if (cs_s)                          held <= 1'b0;
      else if (!held && !hold_s && !sck_s) held <= 1'b1;
      else if (held && hold_s && !sck_s)   held <= 1'b0;
    end
  end

  // frame capture
  logic [6:0] rx_sr;
  logic [2:0] bit_idx, byte_cnt;
  logic [7:0] op_q, adr_q, wdat_q, tx_sr;
  logic [AW-1:0] rd_ptr, raddr;
  logic [7:0] rdata, rx_byte, status;
  logic so_q;

  // commit and status state
  logic cv, cv_stat, wel, pen;
  logic [1:0] bp;
  logic [7:0] cv_addr, cv_data;
  logic [CW-1:0] busy_cnt;
  logic cnt_run, busy_any, handshake;

  assign cnt_run   = (busy_cnt != '0);
  assign busy_any  = cv | cnt_run;
  assign handshake = cv & commit_ready;
  assign status    = pack_status(pen, bp, wel, busy_any);
  assign rx_byte   = {rx_sr, si_s};
  assign raddr     = (byte_cnt == 3'd1) ? rx_byte[AW-1:0] : rd_ptr;

  spimem_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(handshake & ~cv_stat),
    .waddr(cv_addr[AW-1:0]), .wdata(cv_data), .raddr(raddr), .rdata(rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0; bit_idx <= '0; byte_cnt <= '0;
      op_q <= '0; adr_q <= '0; wdat_q <= '0;
      tx_sr <= '0; rd_ptr <= '0; so_q <= 1'b0;
    end else if (cs_fall) begin
      bit_idx <= '0; byte_cnt <= '0; tx_sr <= '0;
    end else if (sck_rise) begin
      rx_sr   <= rx_byte[6:0];
      bit_idx <= bit_idx + 3'd1;
      if (bit_idx == 3'd7) begin
        if (byte_cnt != 3'd7) byte_cnt <= byte_cnt + 3'd1;
        if (byte_cnt == 3'd0) begin
          op_q <= rx_byte;
          if (rx_byte == OP_RDSR) tx_sr <= status;
        end else begin
          if (byte_cnt == 3'd1) adr_q <= rx_byte;
          if (byte_cnt == 3'd2) wdat_q <= rx_byte;
          if (op_q == OP_RDSR) tx_sr <= status;
          if (op_q == OP_READ) begin
            tx_sr  <= rdata;
            rd_ptr <= raddr + 1'b1;
          end
        end
      end
    end else if (sck_fall) begin
      so_q  <= tx_sr[7];
      tx_sr <= {tx_sr[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv <= 1'b0; cv_stat <= 1'b0; cv_addr <= '0; cv_data <= '0;
      wel <= 1'b0; pen <= 1'b0; bp <= '0; busy_cnt <= '0;
    end else begin
      if (cnt_run) busy_cnt <= busy_cnt - 1'b1;
      if (cs_rise && bit_idx == 3'd0) begin
        if (op_q == OP_WREN && byte_cnt == 3'd1) wel <= 1'b1;
        if (op_q == OP_WRDI && byte_cnt == 3'd1) wel <= 1'b0;
        if (op_q == OP_WRITE && byte_cnt == 3'd3 && wel && !busy_any) begin
          cv <= 1'b1; cv_stat <= 1'b0; cv_addr <= adr_q; cv_data <= wdat_q;
        end
        if (op_q == OP_WRSR && byte_cnt == 3'd2 && wel && !busy_any) begin
          cv <= 1'b1; cv_stat <= 1'b1; cv_addr <= '0; cv_data <= adr_q;
        end
      end
      if (handshake) begin
        cv       <= 1'b0;
        wel      <= 1'b0;
        busy_cnt <= CW'(WRITE_CYCLES);
        if (cv_stat) begin
          pen <= cv_data[7];
          bp  <= cv_data[3:2];
        end
      end
    end
  end

  assign so_d             = so_q;
  assign so_oe            = ~cs_s & ~held;
  assign commit_valid     = cv;
  assign commit_is_status = cv_stat;
  assign commit_addr      = cv_addr;
  assign commit_data      = cv_data;
endmodule

// File: rtl/spimem_slave_chk.sv
module spimem_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       held,
  input logic       so_oe,
  input logic       commit_valid,
  input logic       commit_ready,
  input logic [7:0] commit_addr,
  input logic [7:0] commit_data,
  input logic       wel,
  input logic       cnt_run
);
  // R2: pad released when deselected
  a_r2_pad_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !so_oe);

  // R10: pad released while paused
  a_r10_pad_off_paused: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);

  // R7: payload held under back-pressure
  a_r7_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && !commit_ready |=> commit_valid && $stable(commit_addr) && $stable(commit_data));

  // R7: handshake clears wel and starts the busy period
  a_r7_handshake_effects: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid && commit_ready |=> !wel && cnt_run && !commit_valid);

  // R8: no new commit offered while the busy counter runs
  a_r8_no_offer_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(commit_valid) |-> !$past(cnt_run));
endmodule

bind spimem_slave spimem_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .held(held), .so_oe(so_oe),
  .commit_valid(commit_valid), .commit_ready(commit_ready),
  .commit_addr(commit_addr), .commit_data(commit_data),
  .wel(wel), .cnt_run(cnt_run));

// File: tb/spimem_slave_tb.sv
module spimem_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, commit_ready = 1'b1;
  logic so_d, so_oe, commit_valid, commit_is_status;
  logic [7:0] commit_addr, commit_data;
  int errors = 0, checks = 0, hs_count = 0;
  logic last_is_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  spimem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .so_d(so_d), .so_oe(so_oe), .commit_valid(commit_valid), .commit_ready(commit_ready),
    .commit_is_status(commit_is_status), .commit_addr(commit_addr), .commit_data(commit_data));

  always @(posedge clk) if (commit_valid && commit_ready) begin
    hs_count <= hs_count + 1;
    last_is_status <= commit_is_status;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // shifts nbits of txw (MSB first, left-aligned), returns the SO bits in rxw
  task automatic spi_cmd(input int nbits, input logic [31:0] txw, input bit mode3,
                         input int hold_at, output logic [31:0] rxw);
    rxw = '0;
    sck = mode3;
    clks(HALF);
    cs_n = 1'b0;
    clks(HALF);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      if (i == hold_at) begin
        clks(HALF);
        hold_n = 1'b0;
        clks(HALF);
        check("R10 pad released in pause", {31'b0, so_oe}, 32'd0);
        sck = 1'b1; si = ~si;
        clks(HALF);
        sck = 1'b0;
        clks(HALF);
        hold_n = 1'b1;
        clks(HALF);
      end
      si = txw[31-i];
      clks(HALF);
      rxw = {rxw[30:0], so_d};
      sck = 1'b1;
      clks(HALF);
    end
    if (!mode3) sck = 1'b0;
    clks(HALF);
    cs_n = 1'b1;
    clks(4*HALF);
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [31:0] r;
    spi_cmd(16, {8'h05, 24'h0}, 1'b0, -1, r);
    st = r[7:0];
  endtask

  task automatic wait_idle;
    logic [7:0] st;
    bit done = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (!done) begin
        rdsr(st);
        if (!st[0]) done = 1'b1;
      end
    end
    check("R8 busy eventually clears", {31'b0, done}, 32'd1);
  endtask

  task automatic cmd8(input logic [7:0] op);
    logic [31:0] r;
    spi_cmd(8, {op, 24'h0}, 1'b0, -1, r);
  endtask

  task automatic write_byte(input logic [7:0] a, input logic [7:0] d);
    logic [31:0] r;
    cmd8(8'h06);
    spi_cmd(24, {8'h02, a, d, 8'h0}, 1'b0, -1, r);
    wait_idle();
  endtask

  task automatic read_byte(input logic [7:0] a, input bit mode3, input int hold_at,
                           output logic [7:0] d);
    logic [31:0] r;
    spi_cmd(24, {8'h03, a, 16'h0}, mode3, hold_at, r);
    d = r[7:0];
  endtask

  task automatic t_reset;
    logic [7:0] st, d;
    check("R11 so_oe after reset", {31'b0, so_oe}, 32'd0);
    check("R11 commit_valid after reset", {31'b0, commit_valid}, 32'd0);
    rdsr(st);
    check("R3 status after reset", {24'b0, st}, 32'h70);
    read_byte(8'h44, 1'b0, -1, d);
    check("R11 array zero after reset", {24'b0, d}, 32'h00);
  endtask

  task automatic t_wel;
    logic [7:0] st;
    cmd8(8'h06);
    rdsr(st);
    check("R4 wren sets wel", {24'b0, st}, 32'h72);
    cmd8(8'h04);
    rdsr(st);
    check("R4 wrdi clears wel", {24'b0, st}, 32'h70);
  endtask

  task automatic t_write_read;
    logic [7:0] d, st;
    int h0;
    logic [31:0] r;
    h0 = hs_count;
    cmd8(8'h06);
    spi_cmd(24, {8'h02, 8'h10, 8'hA5, 8'h0}, 1'b0, -1, r);
    check("R5 write committed once", hs_count - h0, 32'd1);
    rdsr(st);
    check("R8 busy and wel cleared after commit", {24'b0, st}, 32'h71);
    wait_idle();
    read_byte(8'h10, 1'b0, -1, d);
    check("R1 mode 0 read", {24'b0, d}, 32'hA5);
    read_byte(8'h10, 1'b1, -1, d);
    check("R1 mode 3 read", {24'b0, d}, 32'hA5);
  endtask

  task automatic t_rejects;
    logic [7:0] d, st;
    logic [31:0] r;
    int h0;
    h0 = hs_count;
    spi_cmd(24, {8'h02, 8'h10, 8'hEE, 8'h0}, 1'b0, -1, r);
    check("R5 no commit without wel", hs_count - h0, 32'd0);
    cmd8(8'h06);
    spi_cmd(20, {8'h02, 8'h10, 8'hEE, 8'h0}, 1'b0, -1, r);
    check("R5 incomplete frame discarded", hs_count - h0, 32'd0);
    rdsr(st);
    check("R5 wel kept after discard", {24'b0, st}, 32'h72);
    cmd8(8'h04);
    read_byte(8'h10, 1'b0, -1, d);
    check("R5 array unchanged", {24'b0, d}, 32'hA5);
  endtask

  task automatic t_busy_drop;
    logic [7:0] d, st;
    logic [31:0] r;
    int h0;
    h0 = hs_count;
    cmd8(8'h06);
    spi_cmd(24, {8'h02, 8'h20, 8'h11, 8'h0}, 1'b0, -1, r);
    cmd8(8'h06);
    spi_cmd(24, {8'h02, 8'h20, 8'h22, 8'h0}, 1'b0, -1, r);
    check("R8 write during busy dropped", hs_count - h0, 32'd1);
    wait_idle();
    rdsr(st);
    check("R8 wel kept after dropped write", {24'b0, st}, 32'h72);
    cmd8(8'h04);
    read_byte(8'h20, 1'b0, -1, d);
    check("R8 first write stored", {24'b0, d}, 32'h11);
  endtask

  task automatic t_backpressure;
    logic [7:0] d, st;
    logic [31:0] r;
    commit_ready = 1'b0;
    cmd8(8'h06);
    spi_cmd(24, {8'h02, 8'h30, 8'h5A, 8'h0}, 1'b0, -1, r);
    clks(20);
    check("R7 valid held", {31'b0, commit_valid}, 32'd1);
    check("R7 payload", {16'b0, commit_addr, commit_data}, 32'h305A);
    rdsr(st);
    check("R7 busy while pending", {24'b0, st}, 32'h73);
    commit_ready = 1'b1;
    clks(2);
    check("R7 valid drops at handshake", {31'b0, commit_valid}, 32'd0);
    wait_idle();
    read_byte(8'h30, 1'b0, -1, d);
    check("R7 array written at handshake", {24'b0, d}, 32'h5A);
  endtask

  task automatic t_wrap;
    logic [31:0] r;
    write_byte(8'hFF, 8'h3C);
    write_byte(8'h00, 8'hC3);
    spi_cmd(32, {8'h03, 8'hFF, 16'h0}, 1'b0, -1, r);
    check("R9 stream wraps top to zero", {16'b0, r[15:0]}, 32'h3CC3);
  endtask

  task automatic t_hold;
    logic [7:0] d;
    read_byte(8'h10, 1'b0, 19, d);
    check("R10 read resumes after pause", {24'b0, d}, 32'hA5);
  endtask

  task automatic t_deselected_clocks;
    logic [7:0] st;
    si = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sck = 1'b1; clks(HALF);
      sck = 1'b0; clks(HALF);
    end
    check("R2 pad off while deselected", {31'b0, so_oe}, 32'd0);
    rdsr(st);
    check("R2 no state change from stray clocks", {24'b0, st}, 32'h70);
  endtask

  task automatic t_status_write;
    logic [7:0] st;
    logic [31:0] r;
    int h0;
    h0 = hs_count;
    cmd8(8'h06);
    spi_cmd(16, {8'h01, 8'h8C, 16'h0}, 1'b0, -1, r);
    check("R6 status commit offered", hs_count - h0, 32'd1);
    check("R6 commit flagged as status", {31'b0, last_is_status}, 32'd1);
    wait_idle();
    rdsr(st);
    check("R6 protect bits updated", {24'b0, st}, 32'hFC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clks(5);
    rst_n = 1'b1;
    clks(5);
    t_reset();
    t_wel();
    t_write_read();
    t_rejects();
    t_busy_drop();
    t_backpressure();
    t_wrap();
    t_hold();
    t_deselected_clocks();
    t_status_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule